// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Status Flags

This block receives asynchronous serial frames on a single input line and presents each received character through a small register-style interface. A sampling strobe at sixteen times the bit rate is supplied from outside. The line is synchronised, a falling edge from idle-high is taken as a candidate start bit and confirmed at its midpoint, and data, optional parity and stop bits are then sampled in the middle of each bit period. The frame format comes from static control inputs: data length, parity on or off, and parity sense.

Every finished frame sets a receive-full flag and loads the data register, even when the frame carried a parity or framing error. A second frame that lands while the flag is still set overwrites the data and raises an overrun flag. A one-cycle read strobe stands in for a processor read of the data register and clears the full flag. A separate strobe clears the sticky error flags. The interrupt output is the full flag gated by an enable input. A receiver that is switched on while the line is low does not start until it has seen the line high, so it cannot lock onto the middle of a frame.

Top module: `uart_rx_flags`

## Requirements
- R1: While `rx_en_i` is 0 no frame is received: line activity leaves `full_o` at 0 and `rx_data_o` unchanged.
- R2: After `rx_en_i` rises, a falling edge counts as a start only once the line has been seen high on at least one sampling tick. A line that is low at enable time and then goes high is followed by correct reception of the next frame.
- R3: A low pulse on the line that ends before the start-bit midpoint (tick 8 of 16) is discarded, and `full_o` stays 0.
- R4: The frame has `5 + len_sel_i` data bits (code 0 to 3 gives 5 to 8 bits), least significant bit first. The data appears right-aligned in `rx_data_o` with the unused upper bits at 0.
- R5: With `par_en_i`=1 one parity bit follows the data. `par_odd_i`=0 selects even parity and 1 selects odd parity (data ones plus parity bit). A mismatch sets `par_err_o`.
- R6: A stop bit sampled low sets `frm_err_o`.
- R7: At the end of every frame, with or without errors, `full_o` becomes 1 and `rx_data_o` holds the frame's data, both before the stop bit period ends.
- R8: A one-cycle `rd_stb_i` pulse clears `full_o` on the next clock edge.
- R9: A frame that completes while `full_o` is 1 sets `ovr_err_o` and replaces `rx_data_o` with the new data.
- R10: `irq_o` is 1 exactly when `full_o` and `rie_i` are both 1.
- R11: An `err_clr_i` pulse clears `par_err_o`, `ovr_err_o` and `frm_err_o` on the next clock edge. Each of these flags otherwise stays set once raised.
- R12: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receive enable |
| rxd_i | input | 1 | Serial input line, idle high |
| tick_i | input | 1 | Sampling strobe, 16 per bit period |
| len_sel_i | input | 2 | Data length code: bits = 5 + code |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| rie_i | input | 1 | Receive interrupt enable |
| rd_stb_i | input | 1 | Data register read strobe, one cycle |
| err_clr_i | input | 1 | Error flag clear strobe, one cycle |
| rx_data_o | output | 8 | Received data, right-aligned |
| full_o | output | 1 | Receive data full flag |
| par_err_o | output | 1 | Parity error flag |
| ovr_err_o | output | 1 | Overrun error flag |
| frm_err_o | output | 1 | Framing error flag |
| irq_o | output | 1 | Receive interrupt request |

## Verification
Frame results are due two synchroniser cycles plus one register cycle after the sampling tick at the middle of the stop bit. That point lies about half a bit period, roughly 30 clocks here, before the stop bit ends. The scoreboard monitor therefore compares data, full flag and error flags at the end of the driven stop bit, which is safely after the due cycle and before the next frame can change anything. The read and clear strobes take effect on the next clock edge, and the bench samples on the falling edge that follows. `irq_o` is combinational and is checked in the same sampling slot as `full_o`.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int DATA_W = 8;
  localparam int LEN_W  = 2;
  localparam int OSR    = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              par_err;
    logic              frm_err;
  } rx_frame_t;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q[g] <= 1'b1;
        else if (g == 0) sr_q[g] <= d_i;
        else sr_q[g] <= sr_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OSR_P = OSR,
  parameter int MAX_W = DATA_W,
  parameter int LW    = LEN_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic          line_i,
  input  logic [LW-1:0] len_i,
  input  logic          par_en_i,
  input  logic          par_odd_i,
  output logic          done_o,
  output rx_frame_t     frame_o
);
  localparam int CNT_W = $clog2(OSR_P);
  localparam int BIT_W = $clog2(MAX_W + 1);
  localparam int MIN_W = MAX_W - (2**LW) + 1;
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OSR_P/2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR_P - 1);

  rx_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [BIT_W-1:0] idx_q;
  logic [MAX_W-1:0] sh_q;
  logic             par_q, pbit_q, armed_q, fe_q, done_q;
  logic [BIT_W-1:0] nbits, shamt;

  assign nbits = BIT_W'(MIN_W) + BIT_W'(len_i);
  assign shamt = BIT_W'(MAX_W) - nbits;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
      pbit_q  <= 1'b0;
      armed_q <= 1'b0;
      fe_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!en_i) begin
        state_q <= ST_IDLE;
        armed_q <= 1'b0;
      end else if (tick_i) begin
        unique case (state_q)
          ST_IDLE: begin
            // arm only after the line has been seen at mark level
            if (!armed_q) armed_q <= line_i;
            else if (!line_i) begin
              state_q <= ST_START;
              cnt_q   <= '0;
            end
          end
          ST_START: begin
            if (cnt_q == MID) begin
              cnt_q <= '0;
              if (line_i) state_q <= ST_IDLE;
              else begin
                state_q <= ST_DATA;
                idx_q   <= '0;
                par_q   <= 1'b0;
                sh_q    <= '0;
              end
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_DATA: begin
            if (cnt_q == LAST) begin
              cnt_q <= '0;
              sh_q  <= {line_i, sh_q[MAX_W-1:1]};
              par_q <= par_q ^ line_i;
              if (idx_q == BIT_W'(nbits - 1'b1))
                state_q <= par_en_i ? ST_PAR : ST_STOP;
              else idx_q <= idx_q + 1'b1;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_PAR: begin
            if (cnt_q == LAST) begin
              cnt_q   <= '0;
              pbit_q  <= line_i;
              state_q <= ST_STOP;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_STOP: begin
            if (cnt_q == LAST) begin
              cnt_q   <= '0;
              fe_q    <= ~line_i;
              done_q  <= 1'b1;
              armed_q <= 1'b0;
              state_q <= ST_IDLE;
            end else cnt_q <= cnt_q + 1'b1;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign done_o          = done_q;
  assign frame_o.data    = sh_q >> shamt;
  assign frame_o.par_err = par_en_i & (par_q ^ pbit_q ^ par_odd_i);
  assign frame_o.frm_err = fe_q;

  // R1: disabled receiver sits idle and reports nothing
  p_off_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (state_q == ST_IDLE) && !done_o);

  // R2: no start detection before the line was seen high
  p_arm_first_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !armed_q) |=> state_q == ST_IDLE);

  // R3: a start that fails the midpoint check returns to idle without a frame
  p_glitch_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && state_q == ST_START && cnt_q == MID && line_i)
      |=> state_q == ST_IDLE && !done_o);
endmodule

// File: rtl/rx_status.sv
module rx_status
  import uart_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  rx_frame_t         frame_i,
  input  logic              rd_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o,
  output logic              pe_o,
  output logic              ore_o,
  output logic              fe_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      full_o <= 1'b0;
      pe_o   <= 1'b0;
      ore_o  <= 1'b0;
      fe_o   <= 1'b0;
    end else begin
      if (done_i) begin
        data_o <= frame_i.data;
        full_o <= 1'b1;
      end else if (rd_i) begin
        full_o <= 1'b0;
      end
      if (clr_i) begin
        pe_o  <= done_i & frame_i.par_err;
        fe_o  <= done_i & frame_i.frm_err;
        ore_o <= done_i & full_o;
      end else if (done_i) begin
        pe_o  <= pe_o  | frame_i.par_err;
        fe_o  <= fe_o  | frame_i.frm_err;
        ore_o <= ore_o | full_o;
      end
    end
  end

  p_full_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> full_o);

  p_read_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !done_i) |=> !full_o);

  p_overrun_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && full_o) |=> ore_o);

  p_err_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !done_i) |=> !pe_o && !ore_o && !fe_o);

  p_err_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && fe_o) |=> fe_o);
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags
  import uart_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_en_i,
  input  logic              rxd_i,
  input  logic              tick_i,
  input  logic [LEN_W-1:0]  len_sel_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              rie_i,
  input  logic              rd_stb_i,
  input  logic              err_clr_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              full_o,
  output logic              par_err_o,
  output logic              ovr_err_o,
  output logic              frm_err_o,
  output logic              irq_o
);
  logic      line_s;
  logic      done;
  rx_frame_t frame;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (line_s)
  );

  rx_frame #(.OSR_P(OSR), .MAX_W(DATA_W), .LW(LEN_W)) u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (rx_en_i),
    .tick_i   (tick_i),
    .line_i   (line_s),
    .len_i    (len_sel_i),
    .par_en_i (par_en_i),
    .par_odd_i(par_odd_i),
    .done_o   (done),
    .frame_o  (frame)
  );

  rx_status u_status (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .done_i(done),
    .frame_i(frame),
    .rd_i  (rd_stb_i),
    .clr_i (err_clr_i),
    .data_o(rx_data_o),
    .full_o(full_o),
    .pe_o  (par_err_o),
    .ore_o (ovr_err_o),
    .fe_o  (frm_err_o)
  );

  assign irq_o = rie_i & full_o;
endmodule

// File: tb/uart_rx_flags_tb_top.sv
module uart_rx_flags_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_en_i = 1'b0;
  logic       rxd_i = 1'b1;
  logic       tick_i;
  logic [1:0] len_sel_i = 2'd3;
  logic       par_en_i = 1'b0;
  logic       par_odd_i = 1'b0;
  logic       rie_i = 1'b0;
  logic       rd_stb_i = 1'b0;
  logic       err_clr_i = 1'b0;
  logic [7:0] rx_data_o;
  logic       full_o, par_err_o, ovr_err_o, frm_err_o, irq_o;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    logic [7:0] d;
    bit         pe;
    bit         fe;
    bit         ore;
  } exp_t;
  exp_t exp_q[$];
  event frame_end;

  always #5 clk_i = ~clk_i;

  logic [1:0] tdiv;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tdiv <= '0;
    else tdiv <= tdiv + 1'b1;
  end
  assign tick_i = (tdiv == 2'd3);

  uart_rx_flags dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .rx_en_i(rx_en_i), .rxd_i(rxd_i),
    .tick_i(tick_i), .len_sel_i(len_sel_i), .par_en_i(par_en_i),
    .par_odd_i(par_odd_i), .rie_i(rie_i), .rd_stb_i(rd_stb_i),
    .err_clr_i(err_clr_i), .rx_data_o(rx_data_o), .full_o(full_o),
    .par_err_o(par_err_o), .ovr_err_o(ovr_err_o), .frm_err_o(frm_err_o),
    .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one bit period = 16 ticks = 64 clocks
  task automatic bit_time(input logic v);
    rxd_i = v;
    repeat (64) @(negedge clk_i);
  endtask

  task automatic send_raw(input logic [7:0] d, input bit bad_par, input logic stop_v);
    int   n;
    logic p;
    n = 5 + int'(len_sel_i);
    p = par_odd_i;
    bit_time(1'b0);
    for (int i = 0; i < n; i++) begin
      bit_time(d[i]);
      p ^= d[i];
    end
    if (par_en_i) bit_time(p ^ bad_par);
    bit_time(stop_v);
  endtask

  task automatic send_exp(input logic [7:0] d, input bit bad_par, input logic stop_v,
                          input bit ore);
    exp_t e;
    int   n;
    n = 5 + int'(len_sel_i);
    e.d   = d & 8'((1 << n) - 1);
    e.pe  = par_en_i & bad_par;
    e.fe  = ~stop_v;
    e.ore = ore;
    exp_q.push_back(e);
    send_raw(d, bad_par, stop_v);
    -> frame_end;
    bit_time(1'b1);
  endtask

  task automatic read_data();
    @(negedge clk_i) rd_stb_i = 1'b1;
    @(negedge clk_i) rd_stb_i = 1'b0;
    chk(full_o == 1'b0, "R8", full_o, 0);
  endtask

  task automatic clr_err();
    @(negedge clk_i) err_clr_i = 1'b1;
    @(negedge clk_i) err_clr_i = 1'b0;
  endtask

  // scoreboard monitor: compares at the end of each driven stop bit
  initial begin
    exp_t e;
    forever begin
      @(frame_end);
      if (exp_q.size() == 0) chk(1'b0, "R7", 0, 1);
      else begin
        e = exp_q.pop_front();
        chk(full_o == 1'b1,     "R7", full_o, 1);
        chk(rx_data_o == e.d,   "R4", rx_data_o, e.d);
        chk(par_err_o == e.pe,  "R5", par_err_o, e.pe);
        chk(frm_err_o == e.fe,  "R6", frm_err_o, e.fe);
        chk(ovr_err_o == e.ore, "R9", ovr_err_o, e.ore);
      end
    end
  end

  initial begin
    repeat (100000) @(negedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R12: reset state
    chk({rx_data_o, full_o, par_err_o, ovr_err_o, frm_err_o, irq_o} == '0, "R12",
        {rx_data_o, full_o, par_err_o, ovr_err_o, frm_err_o, irq_o}, 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);

    // R1: disabled receiver ignores a full frame
    send_raw(8'h55, 1'b0, 1'b1);
    bit_time(1'b1);
    chk(full_o == 1'b0, "R1", full_o, 0);
    chk(rx_data_o == 8'h00, "R1", rx_data_o, 0);

    // R2: enable while line is low, then release and send
    rxd_i = 1'b0;
    rx_en_i = 1'b1;
    repeat (80) @(negedge clk_i);
    chk(full_o == 1'b0, "R2", full_o, 0);
    bit_time(1'b1);
    send_exp(8'hA5, 1'b0, 1'b1, 1'b0);
    read_data();

    // R3: short low pulse is discarded
    rxd_i = 1'b0;
    repeat (20) @(negedge clk_i);
    rxd_i = 1'b1;
    repeat (200) @(negedge clk_i);
    chk(full_o == 1'b0, "R3", full_o, 0);

    // R4: several lengths, LSB first, right aligned
    send_exp(8'h3C, 1'b0, 1'b1, 1'b0);
    read_data();
    len_sel_i = 2'd0;
    send_exp(8'hF5, 1'b0, 1'b1, 1'b0);
    read_data();
    len_sel_i = 2'd2;
    send_exp(8'hDA, 1'b0, 1'b1, 1'b0);
    read_data();

    // R5: parity even ok, odd ok, even wrong
    len_sel_i = 2'd3;
    par_en_i = 1'b1;
    par_odd_i = 1'b0;
    send_exp(8'h96, 1'b0, 1'b1, 1'b0);
    read_data();
    par_odd_i = 1'b1;
    send_exp(8'h17, 1'b0, 1'b1, 1'b0);
    read_data();
    par_odd_i = 1'b0;
    send_exp(8'h81, 1'b1, 1'b1, 1'b0);
    read_data();
    chk(par_err_o == 1'b1, "R11", par_err_o, 1);   // sticky
    clr_err();
    chk(par_err_o == 1'b0, "R11", par_err_o, 0);
    par_en_i = 1'b0;

    // R6 / R7: low stop bit still fills the register
    send_exp(8'h42, 1'b0, 1'b0, 1'b0);
    clr_err();
    chk(frm_err_o == 1'b0, "R11", frm_err_o, 0);
    chk(full_o == 1'b1, "R7", full_o, 1);

    // R10: interrupt gating
    chk(irq_o == 1'b0, "R10", irq_o, 0);
    @(negedge clk_i) rie_i = 1'b1;
    @(negedge clk_i);
    chk(irq_o == 1'b1, "R10", irq_o, 1);
    read_data();
    chk(irq_o == 1'b0, "R10", irq_o, 0);

    // R9: overrun without a read in between
    send_exp(8'h11, 1'b0, 1'b1, 1'b0);
    send_exp(8'hEE, 1'b0, 1'b1, 1'b1);
    clr_err();
    chk(ovr_err_o == 1'b0, "R11", ovr_err_o, 0);
    read_data();
    rie_i = 1'b0;

    repeat (10) @(negedge clk_i);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule